// File: doc/BRIEF.md
# Branch Prediction History and Squash Controller

This block keeps one ordered queue of in-flight branch prediction records for each hardware thread. Fetch pushes a record for every prediction it makes. A record holds the instruction sequence number, the branch PC, whether the prediction took its target from the return stack (and which stack slot and target were in use), whether the branch was a call that pushed the stack, and an opaque token of direction-predictor history. New records go in at the youngest end of the queue. A commit retires the oldest record once the pipeline has passed it.

When the pipeline squashes, the block walks the thread's queue from the youngest end. It removes one record per cycle for as long as the record is younger than the squash point. For each removed record it tells the return stack how to repair itself: it either restores a slot and target, or it undoes a speculative push. A squash raised late in the pipeline carries the resolved direction and the corrected target. Once the walk stops, such a squash trains the direction predictor and the target buffer from the record that sits exactly at the squash point, and then drops that record. A squash raised early in the pipeline only discards the younger records. When the processor has a branch delay slot, the squash point is moved back by one sequence number, so that the branch itself is corrected rather than its delay-slot instruction. Predict and commit requests that are made by instructions being squashed in that same cycle are discarded.

Top module: `bp_hist_ctrl`

## Requirements
- R1: A new record is stored at the youngest end of its thread's queue, so a later walk reaches records in reverse order of insertion.
- R2: When a squash is accepted while the block is idle, `busy` rises the next cycle. Each busy cycle examines the youngest record of the squashed thread. If that record's sequence number is greater than the effective squash number, the record is removed. Otherwise the walk ends, and `busy` falls after that cycle. While busy, predict, commit and squash requests are ignored.
- R3: For a removed record that used the return stack, `fix_restore` pulses with the record's slot index and target. For one that did not use the stack but was a call, `fix_undo` pulses instead. For any other record, neither pulses.
- R4: On a late squash, if the walk stops at a record whose sequence number equals the effective squash number, `trn_vld` pulses once with that record's PC and history token, and with the squash's taken flag and corrected target. The record is then removed.
- R5: On a late squash where the queue is empty, or where the stopping record does not match the effective number, no training is emitted and nothing more is removed.
- R6: An early squash never trains and leaves the record at the squash point in the queue.
- R7: With parameter DELAY_SLOT=1, the effective squash number is the squash sequence number minus one. With DELAY_SLOT=0, it is the squash sequence number unchanged.
- R8: In the cycle a squash is accepted, a predict or commit request on the same thread with a sequence number above the effective squash number is discarded. Such a request at or below that number is kept.
- R9: `stk_miss_cnt` increases by one at each training event whose record used the return stack, and holds its value otherwise.
- R10: A commit removes the thread's oldest record when that record's sequence number is not above the commit number. Otherwise the commit has no effect.
- R11: Each thread holds DEPTH records (32 by default). `pred_stall` is high while the requested thread is full or the block is busy, and a predict made while it is high is not stored.
- R12: After reset, all queues are empty, `busy`, `pred_stall`, all repair and training strobes are low, and `stk_miss_cnt` is zero.
- R13: A squash on one thread neither removes nor suppresses the records and requests of another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_vld | input | 1 | Push a prediction record |
| pred_tid | input | TIDW | Thread of the prediction |
| pred_seq | input | SEQW | Sequence number of the predicted instruction |
| pred_pc | input | PCW | Branch PC |
| pred_used_stk | input | 1 | Target came from the return stack |
| pred_stk_idx | input | SIW | Return-stack slot in use at prediction |
| pred_stk_tgt | input | PCW | Return-stack target at prediction |
| pred_call | input | 1 | Branch was a call that pushed the stack |
| pred_hist | input | HW | Opaque direction-history token |
| pred_stall | output | 1 | Predict cannot be accepted this cycle |
| cmt_vld | input | 1 | Commit request |
| cmt_tid | input | TIDW | Thread of the commit |
| cmt_seq | input | SEQW | Committed sequence number |
| sq_vld | input | 1 | Squash request |
| sq_tid | input | TIDW | Thread being squashed |
| sq_seq | input | SEQW | Squash sequence number |
| sq_late | input | 1 | Squash from a back-end stage (trains) |
| sq_taken | input | 1 | Resolved direction of the branch |
| sq_tgt | input | PCW | Corrected target |
| busy | output | 1 | Squash walk in progress |
| fix_tid | output | TIDW | Thread for the stack repair |
| fix_restore | output | 1 | Restore stack slot and target |
| fix_idx | output | SIW | Slot to restore |
| fix_tgt | output | PCW | Target to restore |
| fix_undo | output | 1 | Undo one speculative stack push |
| trn_vld | output | 1 | Train direction predictor and target buffer |
| trn_tid | output | TIDW | Thread of the training |
| trn_pc | output | PCW | PC of the trained branch |
| trn_taken | output | 1 | Actual direction |
| trn_hist | output | HW | History token of the trained record |
| trn_tgt | output | PCW | Corrected target for the target buffer |
| stk_miss_cnt | output | CW | Count of trained records that used the stack |

## Verification
On every cycle, the assertions check several rules. No queue is pushed past its depth or popped when empty. The two ends of a queue never move in the same cycle. The restore and undo strobes are never high together, and they appear only during a walk. Training is always the last cycle of a walk. The miss counter moves only just after a training event. No push gets through while busy, or while a same-cycle squash covers it. The remaining behaviours can only be shown by the bench's scenarios against its behavioural queue model. These are the youngest-first order of repairs, stopping at the squash point, the minus-one shift, discarding or keeping a record whose number sits exactly at the boundary, commit ordering, and the effect of a full queue on the record count later seen in a walk.

// File: rtl/bphq_pkg.sv
package bphq_pkg;
  parameter int SEQW = 16;
  parameter int PCW  = 32;
  parameter int SIW  = 4;
  parameter int HW   = 8;

  typedef struct packed {
    logic [SEQW-1:0] seq;
    logic [PCW-1:0]  pc;
    logic            used;
    logic [SIW-1:0]  sidx;
    logic [PCW-1:0]  stgt;
    logic            call;
    logic [HW-1:0]   hist;
  } rec_t;

  // Effective squash point: a delay slot moves it back to the branch.
  function automatic logic [SEQW-1:0] eff_seq(input logic [SEQW-1:0] s,
                                              input logic dslot);
    return s - {{(SEQW-1){1'b0}}, dslot};
  endfunction

  // Record younger than the squash point.
  function automatic logic is_younger(input logic [SEQW-1:0] rec_seq,
                                      input logic [SEQW-1:0] point);
    return rec_seq > point;
  endfunction
endpackage

// File: rtl/bphq_store.sv
module bphq_store
  import bphq_pkg::*;
#(
  parameter int NT    = 2,
  parameter int DEPTH = 32,
  parameter int TIDW  = 1,
  parameter int CNW   = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_en,
  input  logic [TIDW-1:0]           push_tid,
  input  rec_t                      push_rec,
  input  logic                      hpop_en,
  input  logic [TIDW-1:0]           hpop_tid,
  input  logic                      tpop_en,
  input  logic [TIDW-1:0]           tpop_tid,
  output rec_t [NT-1:0]             head_rec,
  output logic [NT-1:0][SEQW-1:0]   tail_seq,
  output logic [NT-1:0][CNW-1:0]    cnt
);
  localparam int PW = $clog2(DEPTH);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    rec_t           mem [DEPTH];
    logic [PW-1:0]  hp;
    logic [PW-1:0]  tp;
    logic [CNW-1:0] n;
    logic           do_push, do_hpop, do_tpop;

    assign do_push = push_en && (push_tid == TIDW'(t));
    assign do_hpop = hpop_en && (hpop_tid == TIDW'(t));
    assign do_tpop = tpop_en && (tpop_tid == TIDW'(t));

    always_ff @(posedge clk) begin
      if (do_push) mem[hp] <= push_rec;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hp <= '0;
        tp <= '0;
        n  <= '0;
      end else begin
        hp <= hp + PW'(do_push) - PW'(do_hpop);
        tp <= tp + PW'(do_tpop);
        n  <= n + CNW'(do_push) - CNW'(do_hpop) - CNW'(do_tpop);
      end
    end

    assign head_rec[t] = mem[hp - PW'(1)];
    assign tail_seq[t] = mem[tp].seq;
    assign cnt[t]      = n;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      do_push |-> (n < CNW'(DEPTH))); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (do_hpop || do_tpop) |-> (n != '0)); // R2
    AST_ONE_END: assert property (@(posedge clk) disable iff (!rst_n)
      !(do_hpop && do_tpop)); // R10
  end
endmodule

// File: rtl/bphq_gate.sv
module bphq_gate
  import bphq_pkg::*;
#(
  parameter int NT         = 2,
  parameter int TIDW       = 1,
  parameter int CNW        = 6,
  parameter int DEPTH      = 32,
  parameter int DELAY_SLOT = 1
) (
  input  logic                    busy,
  input  logic                    pred_vld,
  input  logic [TIDW-1:0]         pred_tid,
  input  logic [SEQW-1:0]         pred_seq,
  input  logic                    cmt_vld,
  input  logic [TIDW-1:0]         cmt_tid,
  input  logic [SEQW-1:0]         cmt_seq,
  input  logic                    sq_vld,
  input  logic [TIDW-1:0]         sq_tid,
  input  logic [SEQW-1:0]         sq_seq,
  input  logic [NT-1:0][SEQW-1:0] tail_seq,
  input  logic [NT-1:0][CNW-1:0]  cnt,
  output logic [SEQW-1:0]         sq_eff,
  output logic                    sq_go,
  output logic                    pred_full,
  output logic                    push_en,
  output logic                    tpop_en,
  output logic                    push_killed,
  output logic                    cmt_killed
);
  logic cmt_ready;

  assign sq_eff    = eff_seq(sq_seq, DELAY_SLOT != 0);
  assign sq_go     = sq_vld && !busy;
  assign pred_full = (cnt[pred_tid] == CNW'(DEPTH));

  // Requests from instructions the accepted squash is discarding.
  assign push_killed = sq_go && (pred_tid == sq_tid) && is_younger(pred_seq, sq_eff);
  assign cmt_killed  = sq_go && (cmt_tid == sq_tid) && is_younger(cmt_seq, sq_eff);

  assign push_en   = pred_vld && !busy && !pred_full && !push_killed;
  assign cmt_ready = (cnt[cmt_tid] != '0) && !is_younger(tail_seq[cmt_tid], cmt_seq);
  assign tpop_en   = cmt_vld && !busy && !cmt_killed && cmt_ready;
endmodule

// File: rtl/bphq_walk.sv
module bphq_walk
  import bphq_pkg::*;
#(
  parameter int NT   = 2,
  parameter int TIDW = 1,
  parameter int CNW  = 6,
  parameter int CW   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sq_go,
  input  logic [TIDW-1:0]        sq_tid,
  input  logic [SEQW-1:0]        sq_eff,
  input  logic                   sq_late,
  input  logic                   sq_taken,
  input  logic [PCW-1:0]         sq_tgt,
  input  rec_t [NT-1:0]          head_rec,
  input  logic [NT-1:0][CNW-1:0] cnt,
  output logic                   busy,
  output logic                   hpop_en,
  output logic [TIDW-1:0]        hpop_tid,
  output logic [TIDW-1:0]        fix_tid,
  output logic                   fix_restore,
  output logic [SIW-1:0]         fix_idx,
  output logic [PCW-1:0]         fix_tgt,
  output logic                   fix_undo,
  output logic                   trn_vld,
  output logic [TIDW-1:0]        trn_tid,
  output logic [PCW-1:0]         trn_pc,
  output logic                   trn_taken,
  output logic [HW-1:0]          trn_hist,
  output logic [PCW-1:0]         trn_tgt,
  output logic [CW-1:0]          stk_miss_cnt
);
  logic            walking;
  logic [TIDW-1:0] w_tid;
  logic [SEQW-1:0] w_eff;
  logic            w_late, w_taken;
  logic [PCW-1:0]  w_tgt;
  logic [CW-1:0]   miss_q;

  rec_t hd;
  logic nonempty, drop_young, at_point, walk_done;

  assign hd         = head_rec[w_tid];
  assign nonempty   = (cnt[w_tid] != '0);
  assign drop_young = walking && nonempty && is_younger(hd.seq, w_eff);
  assign at_point   = nonempty && (hd.seq == w_eff);
  assign walk_done  = walking && !drop_young;

  assign trn_vld   = walk_done && w_late && at_point;
  assign trn_tid   = w_tid;
  assign trn_pc    = hd.pc;
  assign trn_taken = w_taken;
  assign trn_hist  = hd.hist;
  assign trn_tgt   = w_tgt;

  assign fix_tid     = w_tid;
  assign fix_restore = drop_young && hd.used;
  assign fix_undo    = drop_young && !hd.used && hd.call;
  assign fix_idx     = hd.sidx;
  assign fix_tgt     = hd.stgt;

  assign hpop_en  = drop_young || trn_vld;
  assign hpop_tid = w_tid;
  assign busy     = walking;
  assign stk_miss_cnt = miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking <= 1'b0;
      w_tid   <= '0;
      w_eff   <= '0;
      w_late  <= 1'b0;
      w_taken <= 1'b0;
      w_tgt   <= '0;
      miss_q  <= '0;
    end else begin
      if (sq_go) begin
        walking <= 1'b1;
        w_tid   <= sq_tid;
        w_eff   <= sq_eff;
        w_late  <= sq_late;
        w_taken <= sq_taken;
        w_tgt   <= sq_tgt;
      end else if (walk_done) begin
        walking <= 1'b0;
      end
      if (trn_vld && hd.used) miss_q <= miss_q + CW'(1);
    end
  end

  AST_REPAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fix_restore && fix_undo)); // R3
  AST_REPAIR_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_restore || fix_undo) |-> busy); // R2
  AST_TRAIN_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    trn_vld |=> !busy); // R4
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(trn_vld) |-> $stable(stk_miss_cnt)); // R9
endmodule

// File: rtl/bp_hist_ctrl.sv
module bp_hist_ctrl
  import bphq_pkg::*;
#(
  parameter int NT         = 2,
  parameter int DEPTH      = 32,
  parameter int DELAY_SLOT = 1,
  parameter int CW         = 16,
  parameter int TIDW       = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_vld,
  input  logic [TIDW-1:0]  pred_tid,
  input  logic [SEQW-1:0]  pred_seq,
  input  logic [PCW-1:0]   pred_pc,
  input  logic             pred_used_stk,
  input  logic [SIW-1:0]   pred_stk_idx,
  input  logic [PCW-1:0]   pred_stk_tgt,
  input  logic             pred_call,
  input  logic [HW-1:0]    pred_hist,
  output logic             pred_stall,
  input  logic             cmt_vld,
  input  logic [TIDW-1:0]  cmt_tid,
  input  logic [SEQW-1:0]  cmt_seq,
  input  logic             sq_vld,
  input  logic [TIDW-1:0]  sq_tid,
  input  logic [SEQW-1:0]  sq_seq,
  input  logic             sq_late,
  input  logic             sq_taken,
  input  logic [PCW-1:0]   sq_tgt,
  output logic             busy,
  output logic [TIDW-1:0]  fix_tid,
  output logic             fix_restore,
  output logic [SIW-1:0]   fix_idx,
  output logic [PCW-1:0]   fix_tgt,
  output logic             fix_undo,
  output logic             trn_vld,
  output logic [TIDW-1:0]  trn_tid,
  output logic [PCW-1:0]   trn_pc,
  output logic             trn_taken,
  output logic [HW-1:0]    trn_hist,
  output logic [PCW-1:0]   trn_tgt,
  output logic [CW-1:0]    stk_miss_cnt
);
  localparam int CNW = $clog2(DEPTH + 1);

  rec_t                    push_rec;
  rec_t [NT-1:0]           head_rec;
  logic [NT-1:0][SEQW-1:0] tail_seq;
  logic [NT-1:0][CNW-1:0]  cnt;
  logic [SEQW-1:0]         sq_eff;
  logic                    sq_go, pred_full, push_en, tpop_en;
  logic                    push_killed, cmt_killed;
  logic                    hpop_en;
  logic [TIDW-1:0]         hpop_tid;

  assign push_rec = '{seq: pred_seq, pc: pred_pc, used: pred_used_stk,
                      sidx: pred_stk_idx, stgt: pred_stk_tgt,
                      call: pred_call, hist: pred_hist};
  assign pred_stall = busy || pred_full;

  bphq_gate #(.NT(NT), .TIDW(TIDW), .CNW(CNW), .DEPTH(DEPTH),
              .DELAY_SLOT(DELAY_SLOT)) u_gate (
    .busy(busy), .pred_vld(pred_vld), .pred_tid(pred_tid), .pred_seq(pred_seq),
    .cmt_vld(cmt_vld), .cmt_tid(cmt_tid), .cmt_seq(cmt_seq),
    .sq_vld(sq_vld), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .tail_seq(tail_seq), .cnt(cnt),
    .sq_eff(sq_eff), .sq_go(sq_go), .pred_full(pred_full),
    .push_en(push_en), .tpop_en(tpop_en),
    .push_killed(push_killed), .cmt_killed(cmt_killed)
  );

  bphq_store #(.NT(NT), .DEPTH(DEPTH), .TIDW(TIDW), .CNW(CNW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_en(push_en), .push_tid(pred_tid), .push_rec(push_rec),
    .hpop_en(hpop_en), .hpop_tid(hpop_tid),
    .tpop_en(tpop_en), .tpop_tid(cmt_tid),
    .head_rec(head_rec), .tail_seq(tail_seq), .cnt(cnt)
  );

  bphq_walk #(.NT(NT), .TIDW(TIDW), .CNW(CNW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .sq_go(sq_go), .sq_tid(sq_tid), .sq_eff(sq_eff), .sq_late(sq_late),
    .sq_taken(sq_taken), .sq_tgt(sq_tgt),
    .head_rec(head_rec), .cnt(cnt),
    .busy(busy), .hpop_en(hpop_en), .hpop_tid(hpop_tid),
    .fix_tid(fix_tid), .fix_restore(fix_restore), .fix_idx(fix_idx),
    .fix_tgt(fix_tgt), .fix_undo(fix_undo),
    .trn_vld(trn_vld), .trn_tid(trn_tid), .trn_pc(trn_pc),
    .trn_taken(trn_taken), .trn_hist(trn_hist), .trn_tgt(trn_tgt),
    .stk_miss_cnt(stk_miss_cnt)
  );

  AST_BUSY_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !push_en); // R2
  AST_KILLED_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && !busy && pred_vld && (pred_tid == sq_tid) &&
     (pred_seq > eff_seq(sq_seq, DELAY_SLOT != 0))) |-> !push_en); // R8
  AST_KILLED_CMT: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_killed |-> !tpop_en); // R8
  AST_KILL_NEEDS_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    (push_killed || cmt_killed) |=> busy); // R13
endmodule

// File: tb/tb_bp_hist_ctrl.sv
module tb_bp_hist_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int DEPTH = 32;
  localparam int DS = 1;

  logic clk = 0, rst_n = 0;
  logic pred_vld = 0, pred_used_stk = 0, pred_call = 0;
  logic [0:0] pred_tid = 0, cmt_tid = 0, sq_tid = 0;
  logic [15:0] pred_seq = 0, cmt_seq = 0, sq_seq = 0;
  logic [31:0] pred_pc = 0, pred_stk_tgt = 0, sq_tgt = 0;
  logic [3:0] pred_stk_idx = 0;
  logic [7:0] pred_hist = 0;
  logic cmt_vld = 0, sq_vld = 0, sq_late = 0, sq_taken = 0;
  logic pred_stall, busy, fix_restore, fix_undo, trn_vld, trn_taken;
  logic [0:0] fix_tid, trn_tid;
  logic [3:0] fix_idx;
  logic [31:0] fix_tgt, trn_pc, trn_tgt;
  logic [7:0] trn_hist;
  logic [15:0] stk_miss_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_hist_ctrl #(.NT(NT), .DEPTH(DEPTH), .DELAY_SLOT(DS)) dut (.*);

  typedef struct {int seq; int pc; bit used; int idx; int tgt; bit call; int hist;} mrec_t;
  mrec_t q [NT][$];
  bit m_walk; int m_wtid, m_weff, m_wtaken, m_wtgt, m_miss; bit m_wlate;
  int total = 0, bad = 0, cycles = 0;
  int n_fr = 0, n_fu = 0, n_trn = 0;

  task automatic chk(string tag, string what, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  // One clock: compare outputs against the model, advance the model.
  task automatic cyc();
    bit e_fr, e_fu, e_trn, e_stall, kp, kc;
    int e_idx, e_tgt, e_ftid, e_tpc, e_thist, eff, t;
    mrec_t r;
    #1;
    e_fr = 0; e_fu = 0; e_trn = 0; e_idx = 0; e_tgt = 0; e_ftid = 0; e_tpc = 0; e_thist = 0;
    e_stall = m_walk || (q[pred_tid].size() == DEPTH);
    chk("R2", "busy", busy, m_walk);
    chk("R11", "pred_stall", pred_stall, e_stall);
    chk("R9", "stk_miss_cnt", stk_miss_cnt, m_miss);
    if (m_walk) begin
      t = m_wtid;
      if (q[t].size() > 0 && q[t][0].seq > m_weff) begin
        r = q[t].pop_front();
        e_fr = r.used; e_fu = !r.used && r.call;
        e_idx = r.idx; e_tgt = r.tgt; e_ftid = t;
      end else begin
        if (m_wlate && q[t].size() > 0 && q[t][0].seq == m_weff) begin
          r = q[t].pop_front();
          e_trn = 1; e_tpc = r.pc; e_thist = r.hist;
          if (r.used) m_miss++;
        end
        m_walk = 0;
      end
    end else begin
      eff = int'(sq_seq) - DS;
      kp = sq_vld && (sq_tid == pred_tid) && (int'(pred_seq) > eff);
      kc = sq_vld && (sq_tid == cmt_tid) && (int'(cmt_seq) > eff);
      if (cmt_vld && !kc && q[cmt_tid].size() > 0 && q[cmt_tid][$].seq <= int'(cmt_seq))
        void'(q[cmt_tid].pop_back());
      if (pred_vld && !e_stall && !kp)
        q[pred_tid].push_front('{int'(pred_seq), int'(pred_pc), pred_used_stk,
                                 int'(pred_stk_idx), int'(pred_stk_tgt), pred_call, int'(pred_hist)});
      if (sq_vld) begin
        m_walk = 1; m_wtid = sq_tid; m_weff = eff; m_wlate = sq_late;
        m_wtaken = sq_taken; m_wtgt = sq_tgt;
      end
    end
    chk("R3", "fix_restore", fix_restore, e_fr);
    chk("R3", "fix_undo", fix_undo, e_fu);
    if (e_fr) begin
      chk("R1/R3", "fix_idx", fix_idx, e_idx);
      chk("R1/R3", "fix_tgt", fix_tgt, e_tgt);
      chk("R13", "fix_tid", fix_tid, e_ftid);
    end
    chk("R4", "trn_vld", trn_vld, e_trn);
    if (e_trn) begin
      chk("R4", "trn_pc", trn_pc, e_tpc);
      chk("R4", "trn_hist", trn_hist, e_thist);
      chk("R4", "trn_taken", trn_taken, m_wtaken);
      chk("R4", "trn_tgt", trn_tgt, m_wtgt);
      chk("R13", "trn_tid", trn_tid, m_wtid);
    end
    n_fr += fix_restore; n_fu += fix_undo; n_trn += trn_vld;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clr();
    pred_vld = 0; cmt_vld = 0; sq_vld = 0;
  endtask

  task automatic put(int tid, int seq, bit used, int idx, int tgt, bit call);
    pred_vld = 1; pred_tid = tid[0]; pred_seq = seq[15:0]; pred_pc = 32'h1000 + seq;
    pred_used_stk = used; pred_stk_idx = idx[3:0]; pred_stk_tgt = tgt; pred_call = call;
    pred_hist = seq[7:0] ^ 8'h5a;
    cyc(); clr();
  endtask

  task automatic set_sq(int tid, int seq, bit late, int tgt);
    sq_vld = 1; sq_tid = tid[0]; sq_seq = seq[15:0]; sq_late = late;
    sq_taken = late; sq_tgt = tgt;
  endtask

  task automatic drain();
    for (int i = 0; i < 80 && m_walk; i++) cyc();
  endtask

  task automatic zero_ev();
    n_fr = 0; n_fu = 0; n_trn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12", "busy after reset", busy, 0);
    chk("R12", "stall after reset", pred_stall, 0);
    chk("R12", "miss after reset", stk_miss_cnt, 0);
    chk("R12", "strobes after reset", {fix_restore, fix_undo, trn_vld}, 0);
    @(negedge clk);

    // Fill thread 0 and thread 1
    put(0, 10, 1, 3, 'h100, 0);
    put(0, 11, 0, 0, 0, 1);
    put(0, 12, 0, 0, 0, 0);
    put(0, 13, 1, 5, 'h200, 0);
    put(1, 50, 0, 0, 0, 0);

    // Early squash at 12 -> point 11: removes 13 then 12, keeps 11
    zero_ev(); set_sq(0, 12, 0, 0); cyc(); clr(); drain();
    chk("R2", "restores early squash", n_fr, 1);
    chk("R6", "no training on early squash", n_trn, 0);

    // Late squash at 12 -> point 11 trains from record 11
    zero_ev(); set_sq(0, 12, 1, 'h300); cyc(); clr(); drain();
    chk("R7", "delay-slot shifted training", n_trn, 1);
    chk("R9", "call record no miss", stk_miss_cnt, 0);

    put(0, 20, 1, 7, 'h400, 0);
    zero_ev(); set_sq(0, 21, 1, 'h500); cyc(); clr(); drain();
    chk("R9", "stack record miss", stk_miss_cnt, 1);

    // Commits
    cmt_vld = 1; cmt_tid = 0; cmt_seq = 5; cyc(); clr();
    cmt_vld = 1; cmt_tid = 0; cmt_seq = 10; cyc(); clr();
    cmt_vld = 1; cmt_tid = 1; cmt_seq = 50; cyc(); clr();
    zero_ev(); set_sq(0, 40, 1, 'h600); cyc(); clr(); drain();
    chk("R5", "empty queue no training", n_trn, 0);
    zero_ev(); set_sq(1, 10, 0, 0); cyc(); clr(); drain();
    chk("R10", "thread1 retired by commit", n_fr + n_fu, 0);

    // Mismatch at stopping record
    put(0, 60, 0, 0, 0, 1);
    put(0, 62, 0, 0, 0, 0);
    zero_ev(); set_sq(0, 62, 1, 'h700); cyc(); clr(); drain();
    chk("R5", "mismatch no training", n_trn, 0);
    zero_ev(); set_sq(0, 60, 0, 0); cyc(); clr(); drain();
    chk("R3", "call record undo", n_fu, 1);

    // Same-cycle suppression
    zero_ev(); set_sq(0, 80, 0, 0); pred_vld = 1; pred_tid = 1; pred_seq = 91;
    pred_used_stk = 1; pred_stk_idx = 1; pred_stk_tgt = 'h500; pred_call = 0;
    cyc(); clr(); drain();
    set_sq(0, 80, 0, 0); pred_vld = 1; pred_tid = 0; pred_seq = 79;
    pred_used_stk = 0; pred_call = 0; cyc(); clr(); drain();
    zero_ev(); set_sq(0, 80, 1, 'h800); cyc(); clr(); drain();
    chk("R8", "boundary push kept", n_trn, 1);
    set_sq(0, 100, 0, 0); pred_vld = 1; pred_tid = 0; pred_seq = 101; cyc(); clr(); drain();
    zero_ev(); set_sq(0, 102, 1, 'h900); cyc(); clr(); drain();
    chk("R8", "younger push dropped", n_trn, 0);
    set_sq(1, 200, 0, 0); cmt_vld = 1; cmt_tid = 1; cmt_seq = 201; cyc(); clr(); drain();
    zero_ev(); set_sq(1, 50, 0, 0); cyc(); clr(); drain();
    chk("R13", "other-thread push kept, commit dropped", n_fr, 1);

    // Full queue
    for (int i = 0; i < DEPTH; i++) put(1, 300 + i, 1, i % 16, 'h2000 + i, 0);
    #1; chk("R11", "stall when full", pred_stall, 1);
    put(1, 332, 1, 0, 'h9999, 0);
    zero_ev(); set_sq(1, 300, 0, 0); cyc(); clr(); drain();
    chk("R11", "full queue walk length", n_fr, DEPTH);
    chk("R1", "thread0 untouched by thread1 walk", n_trn, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL R2 watchdog: cycles=%0d expected<=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule